// File: doc/BRIEF.md
# Taskfile Command Write Sequencer

This block sits on the host side of a disk controller. It turns one command request into the ordered series of byte writes that load a drive's taskfile. A request is made of a 48-bit block address, a 16-bit sector count, an operation select, an extended-addressing flag and a drive-select flag, and it is taken with a single-cycle `start_i` pulse. Sectors are 512 bytes, but the block only forwards the count and never moves data. The output is a stream of beats. Each beat is a register address and a data byte, carried on a valid/ready handshake, and a one-cycle `done_o` pulse follows the last beat.

With extended addressing, each paired register (feature, count, the three address bytes) is written twice: first the older, high-order byte, then the newer byte. Without it, each paired register is written once. Address bits 27:24 then go into the low nibble of the drive-select register. The command byte is always the final beat. The bus cycle itself, busy and ready polling, data transfer and error recovery belong to other blocks.

The state machine has these states. `ST_IDLE` waits for `start_i`. `ST_FEAT`, `ST_COUNT`, `ST_LBA_LO`, `ST_LBA_MID` and `ST_LBA_HI` each emit one or two beats, as chosen by a half flag. `ST_DEV` emits the drive-select byte and `ST_CMD` emits the command byte. The transitions are:
- IDLE→FEAT on start.
- Each paired state stays put for its second beat when the half flag is set. Otherwise it moves to the next state on an accepted beat.
- HI→DEV, then DEV→CMD, each on an accepted beat.
- CMD→IDLE on an accepted beat, which also raises done.

Top module: `ata_taskfile_seq`

## Requirements
- R1: After reset, `beat_valid_o` and `done_o` are low.
- R2: A `start_i` pulse in idle captures all request inputs, and the first beat is valid in the next cycle. Register addresses are: feature 1, count 2, address low 3, address mid 4, address high 5, drive select 6, command 7. A valid beat never carries address 0.
- R3: In 28-bit mode the sequence has 7 beats: feature 0x00, count[7:0], lba[7:0], lba[15:8], lba[23:16], drive select, command.
- R4: In 48-bit mode the sequence has 12 beats: feature 0x00 twice, count[15:8], count[7:0], lba[31:24], lba[7:0], lba[39:32], lba[15:8], lba[47:40], lba[23:16], drive select, command.
- R5: The drive-select byte is 0xE0, OR 0x10 when drive 1 is selected. In 28-bit mode it also ORs in lba[27:24]. In 48-bit mode its low nibble is zero.
- R6: The command byte depends on `op_i`. Read (0) gives 0x20 in 28-bit mode and 0x24 in 48-bit mode. Write (1) gives 0x30 and 0x34. Identify (2, and 3) gives 0xEC in either mode.
- R7: A beat shown while `beat_ready_i` is low keeps the same address and data in the next cycle.
- R8: `done_o` is high for exactly one cycle, the cycle after the command beat is accepted, and `beat_valid_o` is low in that cycle.
- R9: A `start_i` pulse while a sequence is running is ignored. The running beats keep their values, and no extra sequence or done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only in idle |
| lba_i | input | 48 | Block address |
| count_i | input | 16 | Sector count |
| op_i | input | 2 | 0 read, 1 write, 2/3 identify |
| ext_i | input | 1 | Extended (48-bit) addressing |
| dev1_i | input | 1 | Select drive 1 |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Downstream accepts the beat |
| beat_addr_o | output | 3 | Taskfile register address |
| beat_data_o | output | 8 | Byte to write |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hold property assumes the downstream side never withdraws a beat it has not taken. It also assumes `start_i` is a single-cycle strobe that is only meaningful in idle. The done properties assume a beat counts as accepted only when valid and ready are both high at a clock edge. The bench changes `beat_ready_i` only just after a clock edge and pulses `start_i` for one cycle. It uses three ready patterns: always high, alternating, and pseudo-random. A deliberate second start is raised in the middle of one sequence.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FEAT,
        ST_COUNT,
        ST_LBA_LO,
        ST_LBA_MID,
        ST_LBA_HI,
        ST_DEV,
        ST_CMD
    } seq_state_e;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_FEAT    = 3'd1;
    localparam logic [REG_AW-1:0] REG_COUNT   = 3'd2;
    localparam logic [REG_AW-1:0] REG_LBA_LO  = 3'd3;
    localparam logic [REG_AW-1:0] REG_LBA_MID = 3'd4;
    localparam logic [REG_AW-1:0] REG_LBA_HI  = 3'd5;
    localparam logic [REG_AW-1:0] REG_DEV     = 3'd6;
    localparam logic [REG_AW-1:0] REG_CMD     = 3'd7;

    localparam logic [7:0] DEV_FIXED = 8'hE0;
    localparam logic [7:0] DEV_ONE   = 8'h10;

    localparam logic [7:0] OPC_RD28  = 8'h20;
    localparam logic [7:0] OPC_RD48  = 8'h24;
    localparam logic [7:0] OPC_WR28  = 8'h30;
    localparam logic [7:0] OPC_WR48  = 8'h34;
    localparam logic [7:0] OPC_IDENT = 8'hEC;

endpackage

// File: rtl/ata_seq_cmd_enc.sv
module ata_seq_cmd_enc
    import ata_seq_pkg::*;
(
    input  logic [1:0] op,
    input  logic       ext,
    output logic [7:0] cmd_byte
);
    always_comb begin
        unique case (op)
            2'd0:    cmd_byte = ext ? OPC_RD48 : OPC_RD28;
            2'd1:    cmd_byte = ext ? OPC_WR48 : OPC_WR28;
            default: cmd_byte = OPC_IDENT;
        endcase
    end
endmodule

// File: rtl/ata_seq_byte_sel.sv
module ata_seq_byte_sel
    import ata_seq_pkg::*;
#(
    parameter int LBA_W = 48,
    parameter int CNT_W = 16
) (
    input  seq_state_e        state,
    input  logic              hi_half,
    input  logic              ext,
    input  logic              dev1,
    input  logic [LBA_W-1:0]  lba,
    input  logic [CNT_W-1:0]  count,
    input  logic [7:0]        cmd_byte,
    output logic [REG_AW-1:0] addr,
    output logic [7:0]        data
);
    logic [7:0] dev_byte;

    always_comb begin
        dev_byte = DEV_FIXED | (dev1 ? DEV_ONE : 8'h00);
        if (!ext) dev_byte[3:0] = lba[27:24];
    end

    always_comb begin
        unique case (state)
            ST_FEAT: begin
                addr = REG_FEAT;
                data = 8'h00;
            end
            ST_COUNT: begin
                addr = REG_COUNT;
                data = hi_half ? count[15:8] : count[7:0];
            end
            ST_LBA_LO: begin
                addr = REG_LBA_LO;
                data = hi_half ? lba[31:24] : lba[7:0];
            end
            ST_LBA_MID: begin
                addr = REG_LBA_MID;
                data = hi_half ? lba[39:32] : lba[15:8];
            end
            ST_LBA_HI: begin
                addr = REG_LBA_HI;
                data = hi_half ? lba[47:40] : lba[23:16];
            end
            ST_DEV: begin
                addr = REG_DEV;
                data = dev_byte;
            end
            ST_CMD: begin
                addr = REG_CMD;
                data = cmd_byte;
            end
            default: begin
                addr = '0;
                data = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/ata_taskfile_seq.sv
module ata_taskfile_seq
    import ata_seq_pkg::*;
#(
    parameter int LBA_W = 48,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        op_i,
    input  logic              ext_i,
    input  logic              dev1_i,
    output logic              beat_valid_o,
    input  logic              beat_ready_i,
    output logic [REG_AW-1:0] beat_addr_o,
    output logic [7:0]        beat_data_o,
    output logic              done_o
);
    seq_state_e        state_q, state_d;
    logic              half_q, half_d;
    logic              done_q, done_d;
    logic [LBA_W-1:0]  lba_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        op_q;
    logic              ext_q, dev1_q;
    logic              take;
    logic              accept;
    logic [7:0]        cmd_byte;

    assign take   = (state_q == ST_IDLE) && start_i;
    assign accept = (state_q != ST_IDLE) && beat_ready_i;

    // next state
    always_comb begin
        state_d = state_q;
        half_d  = half_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_FEAT;
                    half_d  = ext_i;
                end
            end
            ST_FEAT, ST_COUNT, ST_LBA_LO, ST_LBA_MID, ST_LBA_HI: begin
                if (accept) begin
                    if (half_q) begin
                        half_d = 1'b0;
                    end else begin
                        unique case (state_q)
                            ST_FEAT:    state_d = ST_COUNT;
                            ST_COUNT:   state_d = ST_LBA_LO;
                            ST_LBA_LO:  state_d = ST_LBA_MID;
                            ST_LBA_MID: state_d = ST_LBA_HI;
                            default:    state_d = ST_DEV;
                        endcase
                        half_d = (state_q == ST_LBA_HI) ? 1'b0 : ext_q;
                    end
                end
            end
            ST_DEV: begin
                if (accept) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (accept) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            done_q  <= 1'b0;
            lba_q   <= '0;
            cnt_q   <= '0;
            op_q    <= '0;
            ext_q   <= 1'b0;
            dev1_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            done_q  <= done_d;
            if (take) begin
                lba_q  <= lba_i;
                cnt_q  <= count_i;
                op_q   <= op_i;
                ext_q  <= ext_i;
                dev1_q <= dev1_i;
            end
        end
    end

    ata_seq_cmd_enc u_cmd (
        .op       (op_q),
        .ext      (ext_q),
        .cmd_byte (cmd_byte)
    );

    // outputs
    ata_seq_byte_sel #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_sel (
        .state    (state_q),
        .hi_half  (half_q),
        .ext      (ext_q),
        .dev1     (dev1_q),
        .lba      (lba_q),
        .count    (cnt_q),
        .cmd_byte (cmd_byte),
        .addr     (beat_addr_o),
        .data     (beat_data_o)
    );

    always_comb begin
        beat_valid_o = (state_q != ST_IDLE);
        done_o       = done_q;
    end
endmodule

// File: rtl/ata_taskfile_seq_chk.sv
module ata_taskfile_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       beat_valid_o,
    input logic       beat_ready_i,
    input logic [2:0] beat_addr_o,
    input logic [7:0] beat_data_o,
    input logic       done_o
);
    p_addr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> beat_addr_o != 3'd0);

    p_dev_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && beat_addr_o == 3'd6) |-> beat_data_o[7:5] == 3'b111);

    p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !beat_ready_i) |=>
            (beat_valid_o && $stable(beat_addr_o) && $stable(beat_data_o)));

    p_done_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(beat_valid_o && beat_ready_i && beat_addr_o == 3'd7));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !beat_valid_o);
endmodule

bind ata_taskfile_seq ata_taskfile_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_addr_o  (beat_addr_o),
    .beat_data_o  (beat_data_o),
    .done_o       (done_o)
);

// File: tb/ata_taskfile_seq_bench.sv
module ata_taskfile_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] lba_i = '0;
    logic [15:0] count_i = '0;
    logic [1:0]  op_i = '0;
    logic        ext_i = 1'b0;
    logic        dev1_i = 1'b0;
    logic        beat_ready_i = 1'b1;
    logic        beat_valid_o;
    logic [2:0]  beat_addr_o;
    logic [7:0]  beat_data_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ata_taskfile_seq u_ata_taskfile_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lba_i(lba_i),
        .count_i(count_i), .op_i(op_i), .ext_i(ext_i), .dev1_i(dev1_i),
        .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
        .beat_addr_o(beat_addr_o), .beat_data_o(beat_data_o), .done_o(done_o)
    );

    // ready pattern: 0 always, 1 alternating, 2 pseudo-random
    int         ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0: beat_ready_i = 1'b1;
            1: beat_ready_i = ~beat_ready_i;
            default: beat_ready_i = lfsr[0];
        endcase
    end

    // monitor
    logic [2:0] rec_addr [0:15];
    logic [7:0] rec_data [0:15];
    int nbeat, cyc, last_cyc, done_cnt, done_cyc, hold_err, stall_cnt, done_valid_err;
    logic       pv, pr;
    logic [2:0] pa;
    logic [7:0] pd;
    always @(negedge clk) begin
        cyc++;
        if (pv && !pr) begin
            stall_cnt++;
            if (!beat_valid_o || beat_addr_o !== pa || beat_data_o !== pd) hold_err++;
        end
        if (beat_valid_o && beat_ready_i) begin
            if (nbeat < 16) begin
                rec_addr[nbeat] = beat_addr_o;
                rec_data[nbeat] = beat_data_o;
            end
            nbeat++;
            last_cyc = cyc;
        end
        if (done_o) begin
            done_cnt++;
            done_cyc = cyc;
            if (beat_valid_o) done_valid_err++;
        end
        pv = beat_valid_o; pr = beat_ready_i; pa = beat_addr_o; pd = beat_data_o;
    end

    task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [2:0] exp_addr [0:11];
    logic [7:0] exp_data [0:11];
    int         exp_n;

    task automatic build_exp(input logic [1:0] op, input logic ext, input logic dev1,
                             input logic [47:0] lba, input logic [15:0] cnt);
        logic [7:0] dev, cmd;
        dev = 8'hE0 | (dev1 ? 8'h10 : 8'h00) | (ext ? 8'h00 : {4'h0, lba[27:24]});
        if (op == 2'd0)      cmd = ext ? 8'h24 : 8'h20;
        else if (op == 2'd1) cmd = ext ? 8'h34 : 8'h30;
        else                 cmd = 8'hEC;
        if (ext) begin
            exp_n = 12;
            exp_addr = '{3'd1,3'd1,3'd2,3'd2,3'd3,3'd3,3'd4,3'd4,3'd5,3'd5,3'd6,3'd7};
            exp_data = '{8'h00,8'h00,cnt[15:8],cnt[7:0],lba[31:24],lba[7:0],
                         lba[39:32],lba[15:8],lba[47:40],lba[23:16],dev,cmd};
        end else begin
            exp_n = 7;
            exp_addr = '{3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7,3'd0,3'd0,3'd0,3'd0,3'd0};
            exp_data = '{8'h00,cnt[7:0],lba[7:0],lba[15:8],lba[23:16],dev,cmd,
                         8'h00,8'h00,8'h00,8'h00,8'h00};
        end
    endtask

    task automatic run_cmd(input string req, input logic [1:0] op, input logic ext, input logic dev1,
                           input logic [47:0] lba, input logic [15:0] cnt,
                           input int mode, input bit poke);
        int first_cyc;
        build_exp(op, ext, dev1, lba, cnt);
        ready_mode = mode;
        @(posedge clk); #1;
        nbeat = 0; done_cnt = 0; hold_err = 0; stall_cnt = 0; done_valid_err = 0; done_cyc = 0;
        lba_i = lba; count_i = cnt; op_i = op; ext_i = ext; dev1_i = dev1; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        first_cyc = cyc;
        @(negedge clk);
        chk("R2", "valid one cycle after start", beat_valid_o, 1'b1);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            lba_i = ~lba; count_i = ~cnt; op_i = op + 2'd1; ext_i = ~ext; dev1_i = ~dev1;
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        for (int i = 0; i < 400 && done_cnt == 0; i++) @(posedge clk);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(req, "beat count", nbeat, exp_n);
        for (int i = 0; i < 12; i++) begin
            if (i < exp_n && i < nbeat) begin
                chk(req, $sformatf("addr beat %0d", i), rec_addr[i], exp_addr[i]);
                chk(req, $sformatf("data beat %0d", i), rec_data[i], exp_data[i]);
            end
        end
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "done cycle after cmd", done_cyc, last_cyc + 1);
        chk("R8", "valid low with done", done_valid_err, 0);
        chk("R7", "beat held under stall", hold_err, 0);
        chk("R1", "idle after sequence", beat_valid_o, 1'b0);
        if (first_cyc < 0) errors++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "valid in reset", beat_valid_o, 1'b0);
        chk("R1", "done in reset", done_o, 1'b0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", beat_valid_o, 1'b0);
        chk("R1", "done after reset", done_o, 1'b0);
    endtask

    task automatic t_read28();      // R3 R5 R6
        run_cmd("R3", 2'd0, 1'b0, 1'b0, 48'h1234_5A6B_7C8D, 16'h0011, 0, 1'b0);
        run_cmd("R5", 2'd0, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFF, 16'hABCD, 0, 1'b0);
    endtask

    task automatic t_write48();     // R4 R6
        run_cmd("R4", 2'd1, 1'b1, 1'b0, 48'h1234_56AB_CDEF, 16'h0201, 0, 1'b0);
        run_cmd("R6", 2'd1, 1'b0, 1'b0, 48'h0000_0F00_0000, 16'h0000, 0, 1'b0);
        run_cmd("R6", 2'd0, 1'b1, 1'b1, 48'hA5A5_5A5A_C3C3, 16'hFFFF, 0, 1'b0);
    endtask

    task automatic t_identify();    // R6 both widths, op 2 and 3
        run_cmd("R6", 2'd2, 1'b0, 1'b1, 48'h0, 16'h1, 0, 1'b0);
        run_cmd("R6", 2'd3, 1'b1, 1'b0, 48'h0, 16'h1, 0, 1'b0);
    endtask

    task automatic t_backpressure(); // R7
        run_cmd("R7", 2'd1, 1'b1, 1'b1, 48'hFEDC_BA98_7654, 16'h1357, 1, 1'b0);
        chk("R7", "stalls seen alternating", stall_cnt > 0, 1'b1);
        run_cmd("R7", 2'd0, 1'b0, 1'b0, 48'h0000_0A12_3456, 16'h0080, 2, 1'b0);
        chk("R7", "stalls seen random", stall_cnt > 0, 1'b1);
    endtask

    task automatic t_busy_start();   // R9
        run_cmd("R9", 2'd0, 1'b1, 1'b0, 48'h0102_0304_0506, 16'h0708, 1, 1'b1);
        run_cmd("R9", 2'd1, 1'b0, 1'b1, 48'h0000_0B33_2211, 16'h0044, 0, 1'b1);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        nbeat = 0; cyc = 0; last_cyc = 0; done_cnt = 0; done_cyc = 0;
        hold_err = 0; stall_cnt = 0; done_valid_err = 0;
        pv = 1'b0; pr = 1'b0; pa = '0; pd = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_read28();
        t_write48();
        t_identify();
        t_backpressure();
        t_busy_start();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule